// File: doc/BRIEF.md
# Prescaled Free-Running Timebase with Match Flags

This block is a 32-bit up-counter that serves as a shared timebase inside a larger chip. A 3-bit rate code sets how fast it counts. The base clock is divided by a power of two, anywhere from full rate down to one count every 128 cycles. Software drives the block through a small write/read register port. It can switch the whole block off, start and stop counting, zero the count with a one-shot command, and write the count directly.

Two comparators watch the count. Each has its own match value and its own enable bit. When an enabled comparator sees its value on a counting tick, it raises a sticky flag and gives a single-cycle pulse. Each flag can also be forced high or low by write-one command bits in the control word. Both the flag level and the pulse leave the block as plain outputs, for whatever interrupt or pin logic sits around it.

Register map (word addresses): 0 is control, 1 is the count, 2 is the match value of comparator 0, and 3 is the match value of comparator 1.

Control word bit fields:
- [0] on: master activity bit
- [1] go: run enable
- [2] zero command
- [5:3] rate code
- [7:6] comparator enables, bit 6 for comparator 0
- [9:8] set commands
- [11:10] clear commands

Top module: `frc_timebase`

## Requirements
- R1: While control bit 0 (on) is 0, the count does not advance and no comparator flag or pulse is raised by a match, even with bit 1 (go) set.
- R2: With on=1 and go=0 the count holds its value indefinitely.
- R3: Writing control with bit 2 set zeroes the count at that write's clock edge. The bit is not stored, and reading control returns it as 0.
- R4: With on=1, go=1 and rate code n in bits [5:3], the count after N cycles of running from a zero command is floor(N / 2^n), for every n from 0 to 7.
- R5: A write to address 1 loads the count. A read of address 1 returns it.
- R6: An enabled comparator (control bit 6+i) sets its flag match_flag_o[i] at the tick edge where the count before the edge equals its match value. A disabled comparator never sets its flag from a match.
- R7: Control bit 8+i forces flag i to 1 and bit 10+i forces it to 0, one cycle after the write. If both are written together, the flag goes to 0.
- R8: A hardware match in the same cycle as a clear command for that comparator leaves the flag at 1.
- R9: The count wraps from all-ones to zero with no change to any flag.
- R10: match_pulse_o[i] is high for exactly the one cycle after the matching edge, while the flag stays set.
- R11: After reset the count, the match values, the control fields and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| match_flag_o | output | 2 | Sticky match flag per comparator |
| match_pulse_o | output | 2 | One-cycle match pulse per comparator |

## Verification
The bench draws rate codes and run lengths at random and compares the count against floor(N / 2^n). A prescaler with an off-by-one phase, or a code-7 mask that overflows, would show a count one tick high or low.

A clear command is issued on exactly the edge where the count equals the match value. A design that lets the clear win would read the flag as 0 there.

The count is loaded just below all-ones so that it wraps. A design that compared against the wrapped value, or raised a flag on overflow, would show a spurious flag.

Set and clear commands are also written together. The flag must read 0, which catches a design that gives set the priority.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int CNT_W   = 32;
    localparam int DATA_W  = 32;
    localparam int RATE_W  = 3;
    localparam int NUM_CMP = 2;
    localparam int ADDR_W  = $clog2(2 + NUM_CMP);
    localparam int DIV_W   = (1 << RATE_W) - 1;

    // Control word bit positions
    localparam int B_ON   = 0;
    localparam int B_GO   = 1;
    localparam int B_ZERO = 2;
    localparam int B_RATE = 3;
    localparam int B_EN   = B_RATE + RATE_W;
    localparam int B_SET  = B_EN + NUM_CMP;
    localparam int B_CLR  = B_SET + NUM_CMP;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(1);
    localparam int                A_MATCH_BASE = 2;

    typedef struct packed {
        logic [NUM_CMP-1:0] en;
        logic [RATE_W-1:0]  rate;
        logic               go;
        logic               on;
    } frc_ctrl_t;

    // Low bits of the divider that must all be one for a tick.
    function automatic logic [DIV_W-1:0] rate_mask(input logic [RATE_W-1:0] code);
        logic [31:0] m;
        m = (32'd1 << code) - 32'd1;
        return m[DIV_W-1:0];
    endfunction
endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
    parameter int RATE_W = 3,
    localparam int DIV_W = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = frc_pkg::rate_mask(rate);
    assign tick = enable && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !enable || restart) div_q <= '0;
        else                           div_q <= div_q + 1'b1;
    end

    // R4: any divided rate never ticks on two adjacent cycles
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && rate != '0 && !restart && $stable(rate)) |=> !tick);
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             zero,
    input  logic             tick,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst)       count_o <= '0;
        else if (load) count_o <= load_val;
        else if (zero) count_o <= '0;
        else if (tick) count_o <= count_o + 1'b1;
    end

    a_r3_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> (count_o == '0));

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !zero) |=> $stable(count_o));
endmodule

// File: rtl/frc_cmp.sv
module frc_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] match_val,
    input  logic             set_cmd,
    input  logic             clr_cmd,
    output logic             status_o,
    output logic             pulse_o
);
    logic hit;
    assign hit = active && en && tick && (count == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= 1'b0;
            pulse_o  <= 1'b0;
        end else begin
            pulse_o <= hit;
            if (hit)          status_o <= 1'b1;
            else if (clr_cmd) status_o <= 1'b0;
            else if (set_cmd) status_o <= 1'b1;
        end
    end

    a_r10_pulse_has_flag: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> status_o);

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_cmd && !hit) |=> !status_o);

    a_r8_hit_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_cmd) |=> (status_o && pulse_o));
endmodule

// File: rtl/frc_timebase.sv
module frc_timebase
    import frc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_CMP-1:0]   match_flag_o,
    output logic [NUM_CMP-1:0]   match_pulse_o
);
    frc_ctrl_t          ctrl_q;
    logic               ctrl_wr, count_wr, zero_cmd, tick;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   match_q [NUM_CMP];
    logic [NUM_CMP-1:0] set_cmd, clr_cmd;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign count_wr = wr_en && (wr_addr == A_COUNT);
    assign zero_cmd = ctrl_wr && wr_data[B_ZERO];
    assign set_cmd  = ctrl_wr ? wr_data[B_SET +: NUM_CMP] : '0;
    assign clr_cmd  = ctrl_wr ? wr_data[B_CLR +: NUM_CMP] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.on   <= wr_data[B_ON];
            ctrl_q.go   <= wr_data[B_GO];
            ctrl_q.rate <= wr_data[B_RATE +: RATE_W];
            ctrl_q.en   <= wr_data[B_EN +: NUM_CMP];
        end
    end

    frc_prescaler #(.RATE_W(RATE_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .enable  (ctrl_q.on && ctrl_q.go),
        .restart (zero_cmd),
        .rate    (ctrl_q.rate),
        .tick    (tick)
    );

    frc_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (count_wr),
        .load_val (wr_data[CNT_W-1:0]),
        .zero     (zero_cmd),
        .tick     (tick),
        .count_o  (count)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_MATCH_BASE + i);

        always_ff @(posedge clk) begin
            if (rst)                              match_q[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR) match_q[i] <= wr_data[CNT_W-1:0];
        end

        frc_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk       (clk),
            .rst       (rst),
            .active    (ctrl_q.on),
            .en        (ctrl_q.en[i]),
            .tick      (tick),
            .count     (count),
            .match_val (match_q[i]),
            .set_cmd   (set_cmd[i]),
            .clr_cmd   (clr_cmd[i]),
            .status_o  (match_flag_o[i]),
            .pulse_o   (match_pulse_o[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[B_ON]                = ctrl_q.on;
            rd_data[B_GO]                = ctrl_q.go;
            rd_data[B_RATE +: RATE_W]    = ctrl_q.rate;
            rd_data[B_EN +: NUM_CMP]     = ctrl_q.en;
        end else if (rd_addr == A_COUNT) begin
            rd_data[CNT_W-1:0] = count;
        end else begin
            for (int i = 0; i < NUM_CMP; i++)
                if (rd_addr == ADDR_W'(A_MATCH_BASE + i)) rd_data[CNT_W-1:0] = match_q[i];
        end
    end

    // R1: an inactive block keeps its count unless software writes it
    a_r1_inactive_frozen: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.on && !count_wr && !zero_cmd) |=> $stable(count));

    // R1: no match pulse can follow a cycle where the block was off
    a_r1_inactive_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.on |=> (match_pulse_o == '0));
endmodule

// File: tb/frc_timebase_tb_top.sv
module frc_timebase_tb_top;
    import frc_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 wr_en = 1'b0;
    logic [ADDR_W-1:0]    wr_addr = '0;
    logic [DATA_W-1:0]    wr_data = '0;
    logic [ADDR_W-1:0]    rd_addr = '0;
    logic [DATA_W-1:0]    rd_data;
    logic [NUM_CMP-1:0]   match_flag_o;
    logic [NUM_CMP-1:0]   match_pulse_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frc_timebase dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .match_flag_o(match_flag_o), .match_pulse_o(match_pulse_o)
    );

    function automatic logic [31:0] cw(input bit on, input bit go, input bit zero,
                                       input int rate, input logic [1:0] en,
                                       input logic [1:0] set, input logic [1:0] clr);
        logic [31:0] w;
        w = '0;
        w[0] = on; w[1] = go; w[2] = zero;
        w[5:3] = rate[2:0]; w[7:6] = en; w[9:8] = set; w[11:10] = clr;
        return w;
    endfunction

    function automatic logic [31:0] exp_count(input int n_cycles, input int rate);
        return 32'(n_cycles >> rate);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end at a negative clock edge.
    task automatic wr(input int addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        rd_addr = ADDR_W'(addr);
        #1 data = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        rd(1, v); check("R11 count", v, 32'h0);
        rd(0, v); check("R11 ctrl", v, 32'h0);
        rd(2, v); check("R11 match0", v, 32'h0);
        check("R11 flags", {30'h0, match_flag_o}, 32'h0);

        // R5: load and read back the count
        wr(1, 32'h1234_5678);
        rd(1, v); check("R5 count readback", v, 32'h1234_5678);

        // R1: go set but block off, nothing moves
        wr(0, cw(0, 1, 0, 0, 2'b11, 0, 0));
        wr(2, 32'h1234_5679);
        idle(20);
        rd(1, v); check("R1 count frozen", v, 32'h1234_5678);
        check("R1 no flag", {30'h0, match_flag_o}, 32'h0);

        // R3: zero command, not stored
        wr(0, cw(1, 0, 1, 0, 0, 0, 0));
        rd(1, v); check("R3 zeroed", v, 32'h0);
        rd(0, v); check("R3 ctrl reads bit2 as 0", v, 32'h1);

        // R4: directed slowest rate, then random rates and lengths
        wr(0, cw(1, 1, 0, 7, 0, 0, 0));
        idle(300);
        rd(1, v); check("R4 rate7", v, exp_count(300, 7));
        for (int t = 0; t < 12; t++) begin
            int r, n;
            r = int'($urandom % 8);
            n = 1 + int'($urandom % 400);
            wr(0, cw(1, 0, 1, r, 0, 0, 0));
            wr(0, cw(1, 1, 0, r, 0, 0, 0));
            idle(n);
            rd(1, v); check($sformatf("R4 rate%0d n%0d", r, n), v, exp_count(n, r));
        end

        // R2: stop and hold
        wr(0, cw(1, 0, 0, 0, 0, 0, 0));
        rd(1, v); idle(30); rd(1, v2);
        check("R2 hold", v2, v);

        // R6 / R10: comparator 0 enabled, comparator 1 disabled
        wr(0, cw(1, 0, 1, 0, 0, 0, 0));
        wr(2, 32'd5);
        wr(3, 32'd7);
        wr(0, cw(1, 1, 0, 0, 2'b01, 0, 0));
        idle(5);
        rd(1, v); check("R6 count before match", v, 32'd5);
        check("R6 flag0 not yet", {31'h0, match_flag_o[0]}, 32'h0);
        idle(1);
        check("R6 flag0 set", {31'h0, match_flag_o[0]}, 32'h1);
        check("R10 pulse0 high", {31'h0, match_pulse_o[0]}, 32'h1);
        idle(1);
        check("R10 pulse0 one cycle", {31'h0, match_pulse_o[0]}, 32'h0);
        check("R10 flag0 stays", {31'h0, match_flag_o[0]}, 32'h1);
        idle(5);
        check("R6 disabled cmp1", {31'h0, match_flag_o[1]}, 32'h0);

        // R7: commands
        wr(0, cw(1, 0, 0, 0, 2'b01, 2'b00, 2'b01));
        check("R7 clear", {31'h0, match_flag_o[0]}, 32'h0);
        wr(0, cw(1, 0, 0, 0, 2'b01, 2'b10, 2'b00));
        check("R7 set", {31'h0, match_flag_o[1]}, 32'h1);
        wr(0, cw(1, 0, 0, 0, 2'b01, 2'b10, 2'b10));
        check("R7 clear beats set", {31'h0, match_flag_o[1]}, 32'h0);

        // R8: clear lands on the matching edge
        wr(3, 32'd100);
        wr(0, cw(1, 1, 0, 0, 2'b10, 0, 0));
        wr(1, 32'd100);
        wr(0, cw(1, 1, 0, 0, 2'b10, 0, 2'b10));
        check("R8 match beats clear", {31'h0, match_flag_o[1]}, 32'h1);
        check("R8 pulse", {31'h0, match_pulse_o[1]}, 32'h1);

        // R9: wrap without flag change
        wr(0, cw(1, 0, 0, 0, 2'b11, 0, 2'b11));
        wr(2, 32'd3);
        wr(3, 32'd3);
        wr(1, 32'hFFFF_FFFE);
        wr(0, cw(1, 1, 0, 0, 2'b11, 0, 0));
        idle(2);
        rd(1, v); check("R9 wrapped", v, 32'h0);
        check("R9 flags unchanged", {30'h0, match_flag_o}, 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule